// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked system read and write an external asynchronous static RAM that holds 2^ADDR_W words of DATA_W bits. The default is 17 address bits and 8 data bits. The host side is a request/acknowledge port:

- The host raises a one-cycle request carrying a direction, an address and write data.
- While the transaction runs, the block holds busy high.
- When the transaction completes, it pulses a one-cycle acknowledge, with the read data alongside.

On the RAM side the block drives:

- the address;
- a select pair made of one active-low and one active-high chip select;
- an active-low write strobe and an active-low output enable;
- a data bus split into an outgoing value, an incoming value and a driver enable.

Every minimum interval of the RAM is given in nanoseconds and converted at elaboration time into whole clock cycles, rounded up against the clock-period parameter. These intervals are read access, read cycle, output-enable access, write cycle, strobe width, data setup, strobe-to-float and bus release. After every transaction a fixed number of idle cycles with the RAM deselected lets the RAM's output drivers float before anything else uses the bus.

A build option keeps the output enable asserted during writes. In that variant the controller waits the strobe-to-float time after lowering the write strobe before it drives data, and the write pulse is lengthened to match. Between transactions both selects are inactive, so the RAM sits in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever busy is low, the RAM is in standby. The active-low select is 1, the active-high select is 0, the write strobe and output enable are 1, and the driver enable is 0.
- R2: A request presented while busy is low is accepted on that clock edge. Busy reads 1 in the cycle that follows.
- R3: A read keeps the RAM selected with the strobe high and the output enable low for N_RD cycles, where N_RD is the largest of the rounded read-access, read-cycle and output-enable times. The read data is captured on the edge that ends that count and returned unchanged with the acknowledge.
- R4: A write holds the strobe low only while the RAM is selected. The strobe-low time is N_DLY + N_DAT cycles. N_DAT is the largest of: the rounded setup time; the rounded strobe width minus N_DLY; the rounded write cycle minus N_DLY minus 2; and 1. The word driven in the last strobe-low cycle is the one stored.
- R5: The controller never enables its data drivers while the RAM is selected with the strobe high and the output enable low.
- R6: Data drivers switch on only after the strobe has been low for N_DLY cycles. N_DLY is 1 when the output enable is kept high during writes. It is the rounded strobe-to-float time when the output enable is kept low during writes.
- R7: The address does not change while the RAM stays selected.
- R8: Each accepted request yields exactly one acknowledge, one cycle wide.
- R9: A request presented while busy is high is ignored and causes no RAM access.
- R10: After every transaction the RAM is deselected for at least N_TURN cycles (the rounded release time) before busy falls. The acknowledge cycle already shows the RAM deselected with busy still high.
- R11: Counting from the accepting edge, the acknowledge appears N_RD edges later for a read and N_DLY + N_DAT + 2 edges later for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_req | input | 1 | one-cycle transaction request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | word address |
| host_wdata | input | DATA_W | data to store |
| host_busy | output | 1 | transaction in progress; requests ignored |
| host_ack | output | 1 | one-cycle completion pulse |
| host_rdata | output | DATA_W | data from the last read |
| ram_addr | output | ADDR_W | RAM address |
| ram_cs_n | output | 1 | active-low chip select |
| ram_cs | output | 1 | active-high chip select |
| ram_we_n | output | 1 | active-low write strobe |
| ram_oe_n | output | 1 | active-low output enable |
| ram_dq_out | output | DATA_W | data toward the RAM |
| ram_dq_in | input | DATA_W | data from the RAM |
| ram_dq_oe | output | 1 | enable for the controller's data drivers |

## Verification
Two instances share one stimulus stream. One keeps the output enable high during writes and one keeps it low, and each is attached to a behavioural RAM model. The model returns a corrupted word until the address has been stable for the read-access count, so a read captured too early reads back wrong. The model also measures each strobe pulse, and the cycles before data was driven, at the end of every write.

The stimulus consists of:
- an ascending write/read sweep over every address with one arithmetic pattern;
- a descending write sweep with a second pattern, read back in ascending order, which separates address decoding faults from data faults;
- alternating write/read pairs on the same word, which stress turnaround;
- a request injected while busy, whose target word must keep its earlier value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WSET,
      ST_WDLY,
      ST_WDAT,
      ST_WEND
   } seq_st_e;

   // nanoseconds to whole clock cycles, rounded up, never below one
   function automatic int ns_to_cycles(input int ns, input int per_ns);
      int r;
      r = (ns + per_ns - 1) / per_ns;
      if (r < 1) r = 1;
      return r;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_ctrl_pkg::*;
#(
   parameter int N_RD      = 1,
   parameter int N_TURN    = 1,
   parameter int N_DLY     = 1,
   parameter int N_DAT     = 1,
   parameter bit OE_LOW_WR = 1'b0,
   parameter int CNT_W     = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_we,
   input  logic             tmr_exp,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output logic             sel_q,
   output logic             we_n_q,
   output logic             oe_n_q,
   output logic             drv_q,
   output logic             ack_q,
   output logic             busy_q
);

   seq_st_e st_q, st_n;
   logic    fin;
   logic    oe_on;

   always_comb begin
      st_n     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      accept   = 1'b0;
      capture  = 1'b0;
      fin      = 1'b0;
      case (st_q)
         ST_IDLE: if (req) begin
            accept = 1'b1;
            if (req_we) st_n = ST_WSET;
            else begin
               st_n     = ST_RD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(N_RD - 1);
            end
         end
         ST_RD: if (tmr_exp) begin
            capture  = 1'b1;
            fin      = 1'b1;
            st_n     = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_TURN - 1);
         end
         ST_TURN: if (tmr_exp) st_n = ST_IDLE;
         ST_WSET: begin
            st_n     = ST_WDLY;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_DLY - 1);
         end
         ST_WDLY: if (tmr_exp) begin
            st_n     = ST_WDAT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_DAT - 1);
         end
         ST_WDAT: if (tmr_exp) st_n = ST_WEND;
         ST_WEND: begin
            fin      = 1'b1;
            st_n     = ST_TURN;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_TURN - 1);
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // output-enable policy during writes picked at elaboration
   generate
      if (OE_LOW_WR) begin : g_oe_hold
         assign oe_on = (st_n inside {ST_RD, ST_WSET, ST_WDLY, ST_WDAT});
      end else begin : g_oe_rd_only
         assign oe_on = (st_n == ST_RD);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         sel_q  <= 1'b0;
         we_n_q <= 1'b1;
         oe_n_q <= 1'b1;
         drv_q  <= 1'b0;
         ack_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         sel_q  <= st_n inside {ST_RD, ST_WSET, ST_WDLY, ST_WDAT, ST_WEND};
         we_n_q <= !(st_n inside {ST_WDLY, ST_WDAT});
         oe_n_q <= !oe_on;
         drv_q  <= st_n inside {ST_WDAT, ST_WEND};
         ack_q  <= fin;
         busy_q <= (st_n != ST_IDLE);
      end
   end

   a_r8_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> !ack_q);
   a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !accept);
   a_r6_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_q) |-> (!we_n_q && $past(!we_n_q)));
   a_r4_data_at_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(we_n_q) && sel_q) |-> $past(drv_q));

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] ram_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdat_q,
   output logic [DATA_W-1:0] rdat_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wdat_q <= '0;
      end else if (accept) begin
         addr_q <= host_addr;
         wdat_q <= host_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdat_q <= '0;
      else if (capture) rdat_q <= ram_dq_in;
   end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int T_RC_NS   = 12,
   parameter int T_AA_NS   = 12,
   parameter int T_OE_NS   = 6,
   parameter int T_WC_NS   = 12,
   parameter int T_WP_NS   = 8,
   parameter int T_DW_NS   = 7,
   parameter int T_WHZ_NS  = 5,
   parameter int T_HZ_NS   = 6,
   parameter bit OE_LOW_WR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic              host_busy,
   output logic              host_ack,
   output logic [DATA_W-1:0] host_rdata,
   output logic [ADDR_W-1:0] ram_addr,
   output logic              ram_cs_n,
   output logic              ram_cs,
   output logic              ram_we_n,
   output logic              ram_oe_n,
   output logic [DATA_W-1:0] ram_dq_out,
   input  logic [DATA_W-1:0] ram_dq_in,
   output logic              ram_dq_oe
);

   localparam int N_RD   = max2(max2(ns_to_cycles(T_AA_NS, CLK_NS),
                                     ns_to_cycles(T_RC_NS, CLK_NS)),
                                ns_to_cycles(T_OE_NS, CLK_NS));
   localparam int N_TURN = ns_to_cycles(T_HZ_NS, CLK_NS);
   localparam int N_DLY  = OE_LOW_WR ? ns_to_cycles(T_WHZ_NS, CLK_NS) : 1;
   localparam int N_DAT  = max2(max2(ns_to_cycles(T_DW_NS, CLK_NS),
                                     ns_to_cycles(T_WP_NS, CLK_NS) - N_DLY),
                                max2(ns_to_cycles(T_WC_NS, CLK_NS) - N_DLY - 2, 1));
   localparam int N_MAX  = max2(max2(N_RD, N_TURN), max2(N_DLY, N_DAT));
   localparam int CNT_W  = $clog2(N_MAX + 1);

   initial begin
      a_cfg_widths: assert (ADDR_W > 0 && DATA_W > 0)
         else $error("address and data widths must be positive");
      a_cfg_clock: assert (CLK_NS > 0)
         else $error("clock period must be positive");
   end

   logic             tmr_load, tmr_exp, accept, capture;
   logic [CNT_W-1:0] tmr_val;
   logic             sel_q, drv_q;

   sram_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   sram_seq #(
      .N_RD      (N_RD),
      .N_TURN    (N_TURN),
      .N_DLY     (N_DLY),
      .N_DAT     (N_DAT),
      .OE_LOW_WR (OE_LOW_WR),
      .CNT_W     (CNT_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (host_req),
      .req_we   (host_we),
      .tmr_exp  (tmr_exp),
      .tmr_load (tmr_load),
      .tmr_val  (tmr_val),
      .accept   (accept),
      .capture  (capture),
      .sel_q    (sel_q),
      .we_n_q   (ram_we_n),
      .oe_n_q   (ram_oe_n),
      .drv_q    (drv_q),
      .ack_q    (host_ack),
      .busy_q   (host_busy)
   );

   sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .ram_dq_in  (ram_dq_in),
      .addr_q     (ram_addr),
      .wdat_q     (ram_dq_out),
      .rdat_q     (host_rdata)
   );

   assign ram_cs_n  = ~sel_q;
   assign ram_cs    = sel_q;
   assign ram_dq_oe = drv_q;

   a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
      !host_busy |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe));
   a_r5_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      ram_dq_oe |-> !(!ram_cs_n && ram_we_n && !ram_oe_n));
   a_r4_strobe_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_we_n |-> (!ram_cs_n && ram_cs));
   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));
   a_r10_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ram_cs) |=> !ram_cs);

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_model #(
   parameter int AW     = 6,
   parameter int AA_CYC = 3,
   parameter int WLEN   = 3,
   parameter int LEAD   = 1
) (
   input  logic          clk,
   input  logic [AW-1:0] a,
   input  logic          cs_n,
   input  logic          cs,
   input  logic          we_n,
   input  logic          oe_n,
   input  logic [7:0]    d_ctl,
   input  logic          d_oe,
   output logic [7:0]    q
);
   logic [7:0]    mem [2**AW];
   logic [7:0]    lastd;
   logic [AW-1:0] pa;
   logic          prd = 1'b0, pw = 1'b0;
   int            st = 0;
   int            wl = 0, dl = 0, ld = 0;
   int            n_cmp = 0, n_bad = 0;

   wire sel = !cs_n && cs;
   wire rd  = sel && we_n && !oe_n;
   wire wr  = sel && !we_n;

   initial for (int i = 0; i < 2**AW; i++) mem[i] = 8'h00;

   // a word is valid only once its address has been held long enough
   assign q = rd ? ((st >= AA_CYC - 1) ? mem[a] : ~mem[a]) : 8'h00;

   always @(posedge clk) begin
      if (rd) st <= (prd && a == pa) ? st + 1 : 1;
      else    st <= 0;
      pa  <= a;
      prd <= rd;
      if (d_oe && rd) begin
         n_cmp++; n_bad++;
         $display("FAIL R5 bus contention actual=1 expected=0");
      end
      if (wr) begin
         wl++;
         if (d_oe) begin dl++; lastd <= d_ctl; end
         else if (dl == 0) ld++;
      end else if (pw) begin
         n_cmp += 2;
         if (wl != WLEN) begin
            n_bad++;
            $display("FAIL R4 strobe length actual=%0d expected=%0d", wl, WLEN);
         end
         if (ld != LEAD || dl == 0) begin
            n_bad++;
            $display("FAIL R6 cycles before drive actual=%0d expected=%0d", ld, LEAD);
         end
         mem[a] <= lastd;
         wl = 0; dl = 0; ld = 0;
      end
      pw <= wr;
   end
endmodule

module sim_sram_async_ctrl;
   localparam int AW = 6;
   localparam int CP = 20;
   localparam int AA = 45, RC = 45, OE = 6, WC = 90, WP = 30, DW = 15, WHZ = 25, HZ = 10;

   function automatic int cyc(input int ns);
      int r;
      r = (ns + CP - 1) / CP;
      return (r < 1) ? 1 : r;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int E_RD   = mx(mx(cyc(AA), cyc(RC)), cyc(OE));
   localparam int E_DLY0 = 1;
   localparam int E_DLY1 = cyc(WHZ);
   localparam int E_DAT0 = mx(mx(cyc(DW), cyc(WP) - E_DLY0), mx(cyc(WC) - E_DLY0 - 2, 1));
   localparam int E_DAT1 = mx(mx(cyc(DW), cyc(WP) - E_DLY1), mx(cyc(WC) - E_DLY1 - 2, 1));

   logic clk = 1'b0;
   always #(CP/2) clk = ~clk;

   logic          rst_n = 1'b0, req = 1'b0, we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wd = '0;

   logic          busy0, ack0, cs_n0, cs0, we_n0, oe_n0, oe0;
   logic          busy1, ack1, cs_n1, cs1, we_n1, oe_n1, oe1;
   logic [7:0]    rdata0, rdata1, dqo0, dqo1, dqi0, dqi1;
   logic [AW-1:0] ra0, ra1;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CP), .T_RC_NS(RC), .T_AA_NS(AA),
      .T_OE_NS(OE), .T_WC_NS(WC), .T_WP_NS(WP), .T_DW_NS(DW), .T_WHZ_NS(WHZ),
      .T_HZ_NS(HZ), .OE_LOW_WR(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
      .host_wdata(wd), .host_busy(busy0), .host_ack(ack0), .host_rdata(rdata0),
      .ram_addr(ra0), .ram_cs_n(cs_n0), .ram_cs(cs0), .ram_we_n(we_n0),
      .ram_oe_n(oe_n0), .ram_dq_out(dqo0), .ram_dq_in(dqi0), .ram_dq_oe(oe0));

   sram_async_ctrl #(.ADDR_W(AW), .DATA_W(8), .CLK_NS(CP), .T_RC_NS(RC), .T_AA_NS(AA),
      .T_OE_NS(OE), .T_WC_NS(WC), .T_WP_NS(WP), .T_DW_NS(DW), .T_WHZ_NS(WHZ),
      .T_HZ_NS(HZ), .OE_LOW_WR(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we), .host_addr(addr),
      .host_wdata(wd), .host_busy(busy1), .host_ack(ack1), .host_rdata(rdata1),
      .ram_addr(ra1), .ram_cs_n(cs_n1), .ram_cs(cs1), .ram_we_n(we_n1),
      .ram_oe_n(oe_n1), .ram_dq_out(dqo1), .ram_dq_in(dqi1), .ram_dq_oe(oe1));

   sim_sram_model #(.AW(AW), .AA_CYC(E_RD), .WLEN(E_DLY0 + E_DAT0), .LEAD(E_DLY0)) m0 (
      .clk(clk), .a(ra0), .cs_n(cs_n0), .cs(cs0), .we_n(we_n0), .oe_n(oe_n0),
      .d_ctl(dqo0), .d_oe(oe0), .q(dqi0));
   sim_sram_model #(.AW(AW), .AA_CYC(E_RD), .WLEN(E_DLY1 + E_DAT1), .LEAD(E_DLY1)) m1 (
      .clk(clk), .a(ra1), .cs_n(cs_n1), .cs(cs1), .we_n(we_n1), .oe_n(oe_n1),
      .d_ctl(dqo1), .d_oe(oe1), .q(dqi1));

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic standby(input string rq);
      chk(cs_n0 && !cs0 && we_n0 && oe_n0 && !oe0 && !busy0, rq,
          {cs_n0, cs0, we_n0, oe_n0, oe0, busy0}, 6'b101100);
      chk(cs_n1 && !cs1 && we_n1 && oe_n1 && !oe1 && !busy1, rq,
          {cs_n1, cs1, we_n1, oe_n1, oe1, busy1}, 6'b101100);
   endtask

   function automatic logic [7:0] pat(input int a, input int s);
      return 8'((a * 37 + s * 91 + 5) & 255);
   endfunction

   task automatic op(input bit w, input int a, input logic [7:0] d,
                     input logic [7:0] exp_rd, input bit intr);
      int lat0, lat1;
      bit seen0, seen1, p0, p1;
      lat0 = w ? (E_DLY0 + E_DAT0 + 3) : (E_RD + 1);
      lat1 = w ? (E_DLY1 + E_DAT1 + 3) : (E_RD + 1);
      seen0 = 0; seen1 = 0; p0 = 0; p1 = 0;
      @(negedge clk);
      req = 1'b1; we = w; addr = AW'(a); wd = d;
      for (int i = 1; i <= 24; i++) begin
         @(negedge clk);
         if (i == 1) begin
            chk(busy0 && busy1, "R2 busy after accept", {busy0, busy1}, 2'b11);
            if (intr) begin req = 1'b1; we = 1'b1; addr = AW'(a ^ 9); wd = ~d; end
            else req = 1'b0;
         end else req = 1'b0;
         if (ack0) begin
            chk(!seen0 && i == lat0, "R11 u0 ack latency", i, lat0);
            if (!w) chk(rdata0 == exp_rd, "R3 u0 read data", rdata0, exp_rd);
            chk(cs_n0 && !cs0 && busy0, "R10 u0 deselected at ack", {cs_n0, busy0}, 2'b11);
            seen0 = 1;
         end
         if (ack1) begin
            chk(!seen1 && i == lat1, "R11 u1 ack latency", i, lat1);
            if (!w) chk(rdata1 == exp_rd, "R3 u1 read data", rdata1, exp_rd);
            chk(cs_n1 && !cs1 && busy1, "R10 u1 deselected at ack", {cs_n1, busy1}, 2'b11);
            seen1 = 1;
         end
         if (p0 && ack0) chk(0, "R8 u0 ack wider than one cycle", 1, 0);
         if (p1 && ack1) chk(0, "R8 u1 ack wider than one cycle", 1, 0);
         p0 = ack0; p1 = ack1;
      end
      chk(seen0 && seen1, "R8 one ack per request", {seen0, seen1}, 2'b11);
      standby("R1 standby after transaction");
   endtask

   initial begin
      #(CP * 150000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                  n_cmp + m0.n_cmp + m1.n_cmp, n_bad + m0.n_bad + m1.n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      standby("R1 reset state");
      chk(!ack0 && !ack1, "R8 no ack after reset", {ack0, ack1}, 0);

      // ascending sweep, pattern 0
      for (int a = 0; a < 2**AW; a++) op(1, a, pat(a, 0), 8'h00, 0);
      for (int a = 0; a < 2**AW; a++) op(0, a, 8'h00, pat(a, 0), 0);
      // descending write sweep, pattern 1, read back ascending
      for (int a = 2**AW - 1; a >= 0; a--) op(1, a, pat(a, 1), 8'h00, 0);
      for (int a = 0; a < 2**AW; a++) op(0, a, 8'h00, pat(a, 1), 0);

      // R9: a request while busy (write to 3^9 = 10) must be ignored
      op(1, 3, 8'hC3, 8'h00, 1);
      op(0, 10, 8'h00, pat(10, 1), 0);
      op(0, 3, 8'h00, 8'hC3, 0);

      // write/read pairs on one word: turnaround in both directions
      for (int a = 0; a < 8; a++) begin
         op(1, a, 8'(a ^ 8'hA5), 8'h00, 0);
         op(0, a, 8'h00, 8'(a ^ 8'hA5), 0);
      end

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               n_cmp + m0.n_cmp + m1.n_cmp, n_bad + m0.n_bad + m1.n_bad);
      $finish;
   end
endmodule